// File: doc/BRIEF.md
# Selectable-Source Wake-Up Countdown Timer

This block is a one-shot countdown timer for a real-time-clock subsystem. A 12-bit count is loaded through a small register port and then decremented once per source tick. The source is picked by a 2-bit select code out of four rates: the full 4096 Hz base strobe, every 64th base tick, every 4096th base tick (once per second), or an external once-per-minute strobe. All four come from one shared prescaler.

When a decrement takes the count from one to zero, the timer stops by itself. It sets a sticky expiry flag and, if the interrupt enable is set, drives a one-cycle interrupt pulse. Software reads the remaining count back from the same two count registers it wrote. It clears the flag by writing zero to it.

The register port has four byte-wide locations. Address 0 holds count bits 7:0 and address 1 holds count bits 11:8. Address 2 is the mode register: bits 1:0 are the source select and bit 4 is the run bit. Address 3 is the status register: bit 0 is the interrupt enable and bit 1 is the expiry flag. Read data is registered and appears one clock after the read address is presented.

Top module: `wake_countdown`

## Requirements
- R1: After reset the count is 0, the source select is 2'b10, the timer is stopped, the interrupt enable and the flag are 0, and irq_o is low. Address 2 then reads 8'h02 and addresses 0, 1 and 3 read 8'h00.
- R2: A write to address 0 loads count bits 7:0. A write to address 1 loads count bits 11:8 from wr_data[3:0] and ignores wr_data[7:4]. Address 1 reads back with bits 7:4 zero.
- R3: The source select in mode bits 1:0 sets which strobe decrements the count. 2'b11 uses every base tick, 2'b00 every 64th base tick, 2'b01 every 4096th base tick, and 2'b10 each minute_stb pulse. A strobe that is not the selected source has no effect, and nothing decrements while tick_base is low.
- R4: Every write to the mode register restarts the prescaler phase, so the first decrement comes one full source period after that write.
- R5: Writing the mode register with bit 4 set starts the countdown. Writing it with bit 4 clear stops the countdown and the count holds. Mode bit 4 reads 1 while the timer is running.
- R6: Starting with a count of zero leaves the timer stopped and sets neither the flag nor the interrupt.
- R7: When a decrement takes the count from 1 to 0, the timer stops and the flag (status bit 1) is set, whether or not the interrupt is enabled.
- R8: At expiry, irq_o is high for exactly one clock, in the cycle the flag becomes set, and only if the interrupt enable (status bit 0) was set. No other event raises irq_o.
- R9: Writing the status register with bit 1 at 0 clears the flag. Writing bit 1 as 1 leaves it unchanged. The flag does not re-assert until the next expiry.
- R10: Each source tick lowers the count by exactly one. In a cycle with a write to the count or mode registers, the write takes effect and no decrement happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_base | input | 1 | One-cycle 4096 Hz base strobe |
| minute_stb | input | 1 | One-cycle once-per-minute strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Registered read data, one cycle after rd_addr |
| flag_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | One-cycle expiry interrupt pulse |

## Verification
The countdown is run at each of the four source codes with the base strobe held high. The exact cycle of each interrupt separates the divide ratios: 5, 128 and 4096 cycles for the three base-derived rates. For the minute source, base ticks are shown to be ignored and only strobe pulses count. A switch from the once-per-second source to the fast source midway through a period tells a restarted prescaler apart from one that keeps its phase, because the expiry lands exactly 64 cycles after the switch. Runs with the interrupt disabled, with a zero start count, with the base strobe gated off and with a stop in mid-count each show which observable state the timer may and may not change.

// File: rtl/wkc_pkg.sv
`timescale 1ns/1ps
package wkc_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    SRC_FAST = 2'b00,
    SRC_SEC  = 2'b01,
    SRC_MIN  = 2'b10,
    SRC_BASE = 2'b11
  } src_sel_e;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 2'd1;
  localparam logic [ADDR_W-1:0] A_MODE   = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT   = 2'd3;

  localparam int MODE_RUN_BIT  = 4;
  localparam int STAT_IE_BIT   = 0;
  localparam int STAT_FLAG_BIT = 1;
endpackage

// File: rtl/wkc_div.sv
`timescale 1ns/1ps
module wkc_div #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst || clr) ph_q <= '0;
    else if (en) ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
  end

  assign hit = en && (ph_q == LAST);
endmodule

// File: rtl/wkc_prescale.sv
`timescale 1ns/1ps
module wkc_prescale
  import wkc_pkg::*;
#(
  parameter int FAST_DIV = 64,
  parameter int SEC_DIV  = 4096
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     restart,
  input  logic     tick_base,
  input  logic     minute_stb,
  input  src_sel_e sel,
  output logic     src_tick
);
  localparam int NDIV = 2;
  localparam int DIVS [NDIV] = '{FAST_DIV, SEC_DIV};

  logic [NDIV-1:0] hit;

  for (genvar i = 0; i < NDIV; i++) begin : g_div
    wkc_div #(.DIV(DIVS[i])) u_div (
      .clk(clk), .rst(rst), .clr(restart), .en(tick_base), .hit(hit[i])
    );
  end

  always_comb begin
    unique case (sel)
      SRC_FAST: src_tick = hit[0];
      SRC_SEC:  src_tick = hit[1];
      SRC_MIN:  src_tick = minute_stb;
      default:  src_tick = tick_base;
    endcase
  end
endmodule

// File: rtl/wkc_core.sv
`timescale 1ns/1ps
module wkc_core #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             wr_mode,
  input  logic [7:0]       wdata,
  input  logic             run_req,
  input  logic             src_tick,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             running_q,
  output logic             flag_q,
  output logic             irq_q
);
  localparam int HI_W = CNT_W - 8;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
      flag_q    <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (flag_clr) flag_q <= 1'b0;
      if (wr_lo) begin
        cnt_q[7:0] <= wdata;
      end else if (wr_hi) begin
        cnt_q[CNT_W-1:8] <= wdata[HI_W-1:0];
      end else if (wr_mode) begin
        running_q <= run_req && (cnt_q != '0);
      end else if (running_q && src_tick) begin
        if (cnt_q == '0) begin
          running_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - ONE;
          if (cnt_q == ONE) begin
            running_q <= 1'b0;
            flag_q    <= 1'b1;
            irq_q     <= irq_en;
          end
        end
      end
    end
  end
endmodule

// File: rtl/wkc_regs.sv
`timescale 1ns/1ps
module wkc_regs
  import wkc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        sel_in,
  input  logic              ie_in,
  input  logic              flag_in,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              running,
  input  logic              flag,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              wr_mode,
  output logic              flag_clr,
  output src_sel_e          sel_q,
  output logic              irq_en_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam int HI_W = CNT_W - 8;

  logic wr_stat;
  logic [DATA_W-1:0] rd_d;

  assign wr_lo    = wr_en && (wr_addr == A_CNT_LO);
  assign wr_hi    = wr_en && (wr_addr == A_CNT_HI);
  assign wr_mode  = wr_en && (wr_addr == A_MODE);
  assign wr_stat  = wr_en && (wr_addr == A_STAT);
  assign flag_clr = wr_stat && !flag_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= SRC_MIN;
      irq_en_q <= 1'b0;
    end else begin
      if (wr_mode) sel_q <= src_sel_e'(sel_in);
      if (wr_stat) irq_en_q <= ie_in;
    end
  end

  always_comb begin
    rd_d = '0;
    unique case (rd_addr)
      A_CNT_LO: rd_d = cnt[7:0];
      A_CNT_HI: rd_d[HI_W-1:0] = cnt[CNT_W-1:8];
      A_MODE: begin
        rd_d[1:0]          = sel_q;
        rd_d[MODE_RUN_BIT] = running;
      end
      default: begin
        rd_d[STAT_IE_BIT]   = irq_en_q;
        rd_d[STAT_FLAG_BIT] = flag;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_d;
  end
endmodule

// File: rtl/wake_countdown.sv
`timescale 1ns/1ps
module wake_countdown
  import wkc_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int FAST_DIV = 64,
  parameter int SEC_DIV  = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_base,
  input  logic              minute_stb,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              flag_o,
  output logic              irq_o
);
  logic             wr_lo, wr_hi, wr_mode, flag_clr;
  src_sel_e         sel_q;
  logic             irq_en_q;
  logic             src_tick;
  logic [CNT_W-1:0] cnt_q;
  logic             running_q;
  logic             flag_q;
  logic             irq_q;

  wkc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .sel_in(wr_data[1:0]), .ie_in(wr_data[STAT_IE_BIT]),
    .flag_in(wr_data[STAT_FLAG_BIT]),
    .rd_addr(rd_addr), .cnt(cnt_q), .running(running_q), .flag(flag_q),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_mode(wr_mode), .flag_clr(flag_clr),
    .sel_q(sel_q), .irq_en_q(irq_en_q), .rd_data(rd_data)
  );

  wkc_prescale #(.FAST_DIV(FAST_DIV), .SEC_DIV(SEC_DIV)) u_pre (
    .clk(clk), .rst(rst), .restart(wr_mode),
    .tick_base(tick_base), .minute_stb(minute_stb),
    .sel(sel_q), .src_tick(src_tick)
  );

  wkc_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_mode(wr_mode),
    .wdata(wr_data), .run_req(wr_data[MODE_RUN_BIT]),
    .src_tick(src_tick), .irq_en(irq_en_q), .flag_clr(flag_clr),
    .cnt_q(cnt_q), .running_q(running_q), .flag_q(flag_q), .irq_q(irq_q)
  );

  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/wkc_checker.sv
`timescale 1ns/1ps
module wkc_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             irq_o,
  input logic             flag_o,
  input logic             irq_en,
  input logic             running,
  input logic [CNT_W-1:0] cnt
);
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o); // R8

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(irq_en)); // R8

  AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o); // R7

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && (cnt != $past(cnt))) |-> (cnt == $past(cnt) - CNT_W'(1))); // R10

  AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && $past(running) && ($past(cnt) == CNT_W'(1)) && (cnt == '0))
      |-> (!running && flag_o)); // R7
endmodule

bind wake_countdown wkc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .irq_o(irq_o), .flag_o(flag_o),
  .irq_en(irq_en_q), .running(running_q), .cnt(cnt_q)
);

// File: tb/tb_wake_countdown.sv
`timescale 1ns/1ps
module tb_wake_countdown;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_base = 1'b0;
  logic       minute_stb = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  wire  [7:0] rd_data;
  wire        flag_o;
  wire        irq_o;

  wake_countdown dut (
    .clk(clk), .rst(rst), .tick_base(tick_base), .minute_stb(minute_stb),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .flag_o(flag_o), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    n_chk = 0;
  int    n_fail = 0;
  int    exp_q[$];
  string tag_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every interrupt pulse must match the next expected cycle
  always @(posedge clk) begin
    int    e;
    string t;
    #1;
    if (!rst && irq_o) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R8 unexpected irq: actual cycle %0d expected none", cyc);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, cyc, e);
      end
    end
  end

  task automatic push_irq(input int at, input string tag);
    exp_q.push_back(at);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int cw);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 cw = cyc;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    #1 v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int cw, cw2, c;
    logic [7:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(2'd0, v); check("R1 count lo", v, 8'h00);
    rd(2'd1, v); check("R1 count hi", v, 8'h00);
    rd(2'd2, v); check("R1 mode", v, 8'h02);
    rd(2'd3, v); check("R1 status", v, 8'h00);
    check("R1 flag_o", flag_o, 1'b0);
    check("R1 irq_o", irq_o, 1'b0);

    // R2 count register access
    wr(2'd0, 8'hA5, cw);
    wr(2'd1, 8'hF3, cw);
    rd(2'd0, v); check("R2 lo readback", v, 8'hA5);
    rd(2'd1, v); check("R2 hi readback upper ignored", v, 8'h03);

    // R7 R8 R10 base-rate expiry with interrupt enabled
    wr(2'd3, 8'h01, cw);
    @(negedge clk) tick_base = 1'b1;
    wr(2'd0, 8'd5, cw);
    wr(2'd1, 8'h00, cw);
    wr(2'd2, 8'h13, cw);
    push_irq(cw + 5, "R10 sel11 expiry cycle");
    idle(10);
    rd(2'd0, v); check("R7 count zero after expiry", v, 8'h00);
    rd(2'd2, v); check("R7 stopped after expiry", v, 8'h03);
    check("R7 flag set", flag_o, 1'b1);

    // R9 flag clear semantics
    wr(2'd3, 8'h03, cw);
    check("R9 writing 1 keeps flag", flag_o, 1'b1);
    wr(2'd3, 8'h01, cw);
    check("R9 writing 0 clears flag", flag_o, 1'b0);
    idle(5);
    rd(2'd3, v); check("R9 flag stays clear", v, 8'h01);

    // R8 interrupt disabled: flag only, monitor catches any pulse
    wr(2'd3, 8'h00, cw);
    wr(2'd0, 8'd3, cw);
    wr(2'd2, 8'h13, cw);
    idle(10);
    check("R7 flag set with irq disabled", flag_o, 1'b1);
    rd(2'd0, v); check("R8 count expired without irq", v, 8'h00);
    wr(2'd3, 8'h01, cw);

    // R6 zero start
    wr(2'd0, 8'd0, cw);
    wr(2'd2, 8'h13, cw);
    idle(20);
    rd(2'd2, v); check("R6 zero start stays stopped", v, 8'h03);
    check("R6 zero start no flag", flag_o, 1'b0);

    // R3 divide by 64
    wr(2'd0, 8'd2, cw);
    wr(2'd2, 8'h10, cw);
    push_irq(cw + 128, "R3 sel00 expiry cycle");
    idle(140);
    rd(2'd0, v); check("R3 sel00 count zero", v, 8'h00);

    // R4 prescaler restart on select change
    wr(2'd3, 8'h01, cw);
    wr(2'd0, 8'd1, cw);
    wr(2'd2, 8'h11, cw);
    idle(100);
    wr(2'd2, 8'h10, cw2);
    push_irq(cw2 + 64, "R4 restart expiry cycle");
    idle(80);

    // R3 divide by 4096
    wr(2'd3, 8'h01, cw);
    wr(2'd0, 8'd1, cw);
    wr(2'd2, 8'h11, cw);
    push_irq(cw + 4096, "R3 sel01 expiry cycle");
    idle(4110);
    check("R3 sel01 flag", flag_o, 1'b1);

    // R5 start, base gating and stop
    wr(2'd3, 8'h01, cw);
    @(negedge clk) tick_base = 1'b0;
    wr(2'd0, 8'd9, cw);
    wr(2'd2, 8'h13, cw);
    idle(5);
    rd(2'd2, v); check("R5 running bit", v, 8'h13);
    rd(2'd0, v); check("R3 no decrement without base tick", v, 8'd9);
    @(negedge clk) tick_base = 1'b1;
    repeat (3) @(negedge clk);
    tick_base = 1'b0;
    rd(2'd0, v); check("R10 three ticks three decrements", v, 8'd6);
    wr(2'd2, 8'h03, cw);
    @(negedge clk) tick_base = 1'b1;
    idle(10);
    rd(2'd0, v); check("R5 stopped count holds", v, 8'd6);
    rd(2'd2, v); check("R5 stopped run bit", v, 8'h03);

    // R3 minute source
    wr(2'd0, 8'd2, cw);
    wr(2'd2, 8'h12, cw);
    idle(20);
    rd(2'd0, v); check("R3 base ticks ignored in minute mode", v, 8'd2);
    @(negedge clk) minute_stb = 1'b1;
    @(negedge clk) minute_stb = 1'b0;
    rd(2'd0, v); check("R3 one minute strobe", v, 8'd1);
    @(negedge clk) minute_stb = 1'b1;
    c = cyc;
    push_irq(c + 1, "R3 minute expiry cycle");
    @(negedge clk) minute_stb = 1'b0;
    idle(3);
    check("R7 minute flag", flag_o, 1'b1);
    rd(2'd2, v); check("R7 minute stopped", v, 8'h02);

    idle(5);
    check("R8 all expected irqs seen", exp_q.size(), 0);
    finish_run();
  end
endmodule